// File: doc/BRIEF.md
# Two-Master Transaction-Holding Bus Arbiter

This block decides which of two bus masters may drive a shared bus. While no master owns the bus, it samples both request lines. On a clock edge where at least one request is present, it hands the bus to one master. Master 1 wins whenever its request is present. Master 2 wins only when its request is present and master 1's is not.

Once a grant is issued, it is not re-arbitrated cycle by cycle. The owning master keeps the bus until it raises its own transfer-complete (ready) line. At that point the arbiter drops the grant and goes back to sampling requests.

Requests that come and go while the bus is owned leave no trace. A master that still wants the bus must be requesting when the arbiter is free again. The ready line of the master that is not the owner is ignored.

Top module: `bus_hold_arb`

## Requirements
- R1: While `rst` is high at a rising clock edge, both grants are low in the following cycle and the arbiter is free.
- R2: While the arbiter is free and neither request is present at an edge, both grants stay low after that edge.
- R3: While free, if `req_m1` is high at an edge, `gnt_m1` is high from the next cycle.
- R4: While free, if both requests are high at the same edge, master 1 is granted and `gnt_m2` stays low.
- R5: While free, if `req_m2` is high and `req_m1` is low at an edge, `gnt_m2` is high from the next cycle.
- R6: A grant stays high on every cycle until the owner's ready is seen at an edge, whatever the request lines do.
- R7: The ready line of the master that does not own the bus has no effect on either grant.
- R8: When the owner's ready is high at an edge, both grants are low in the next cycle. A new grant can appear no earlier than the cycle after that.
- R9: At most one grant is high in any cycle.
- R10: A request raised and dropped while the bus is owned is not remembered. If neither request is present once the arbiter is free, no grant follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_m1 | input | 1 | Bus request from master 1 (higher priority) |
| req_m2 | input | 1 | Bus request from master 2 |
| rdy_m1 | input | 1 | Transfer-complete from master 1 |
| rdy_m2 | input | 1 | Transfer-complete from master 2 |
| gnt_m1 | output | 1 | Bus grant to master 1, registered |
| gnt_m2 | output | 1 | Bus grant to master 2, registered |

## Verification
The grants are decoded directly from the ownership register, so a wrong internal state shows at the grant pins in the very next cycle. Typical symptoms are a grant appearing for the wrong master, a grant lingering after the owner's ready, or a grant dropped early by the other master's ready. The bench compares the grants against a reference model on every clock. A divergence is therefore reported in the first cycle the state is wrong, rather than at the end of a transfer.

// File: rtl/bha_pkg.sv
package bha_pkg;
   localparam int unsigned N_MST = 2;
   localparam int unsigned ST_W  = 2;

   typedef enum logic [ST_W-1:0] {
      ARB_FREE  = 2'd0,
      ARB_OWN_A = 2'd1,
      ARB_OWN_B = 2'd2
   } arb_state_e;
endpackage

// File: rtl/bha_pick.sv
module bha_pick
   import bha_pkg::*;
#(
   parameter int unsigned NM = N_MST
) (
   input  logic [NM-1:0] req,
   output logic [NM-1:0] pick
);
   // fixed priority: index 0 beats every higher index
   genvar gi;
   generate
      for (gi = 0; gi < NM; gi++) begin : g_prio
         if (gi == 0) begin : g_top
            assign pick[gi] = req[gi];
         end else begin : g_low
            assign pick[gi] = req[gi] && (req[gi-1:0] == '0);
         end
      end
   endgenerate

   initial begin
      if (NM < 1) $error("bha_pick: NM must be at least 1");
   end
endmodule

// File: rtl/bha_release.sv
module bha_release
   import bha_pkg::*;
#(
   parameter int unsigned NM = N_MST
) (
   input  logic [NM-1:0] rdy,
   input  logic [NM-1:0] own,
   output logic          done
);
   // only the owner's ready line can end the tenure
   assign done = |(rdy & own);
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
   import bha_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [N_MST-1:0] req,
   input  logic [N_MST-1:0] pick,
   input  logic [N_MST-1:0] rdy,
   input  logic             done,
   output logic [N_MST-1:0] gnt
);
   arb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_FREE: begin
            if (pick[0])      state_d = ARB_OWN_A;
            else if (pick[1]) state_d = ARB_OWN_B;
         end
         ARB_OWN_A, ARB_OWN_B: begin
            if (done) state_d = ARB_FREE;
         end
         default: state_d = ARB_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ARB_FREE;
      else     state_q <= state_d;
   end

   assign gnt[0] = (state_q == ARB_OWN_A);
   assign gnt[1] = (state_q == ARB_OWN_B);

   // R9
   grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));

   // R3
   first_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ARB_FREE && req[0]) |=> (gnt[0] && !gnt[1]));

   // R5
   second_alone_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ARB_FREE && req[1] && !req[0]) |=> gnt[1]);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ARB_FREE && req == '0) |=> (gnt == '0));

   // R7
   hold_a_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt[0] && !rdy[0]) |=> gnt[0]);

   // R7
   hold_b_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt[1] && !rdy[1]) |=> gnt[1]);

   // R8
   release_chk: assert property (@(posedge clk) disable iff (rst)
      ((gnt[0] && rdy[0]) || (gnt[1] && rdy[1])) |=> (gnt == '0));
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
   import bha_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_m1,
   input  logic req_m2,
   input  logic rdy_m1,
   input  logic rdy_m2,
   output logic gnt_m1,
   output logic gnt_m2
);
   logic [N_MST-1:0] req_v, rdy_v, pick_v, gnt_v;
   logic             done_w;

   assign req_v = {req_m2, req_m1};
   assign rdy_v = {rdy_m2, rdy_m1};

   bha_pick #(.NM(N_MST)) u_pick (
      .req  (req_v),
      .pick (pick_v)
   );

   bha_release #(.NM(N_MST)) u_rel (
      .rdy  (rdy_v),
      .own  (gnt_v),
      .done (done_w)
   );

   bha_fsm u_fsm (
      .clk  (clk),
      .rst  (rst),
      .req  (req_v),
      .pick (pick_v),
      .rdy  (rdy_v),
      .done (done_w),
      .gnt  (gnt_v)
   );

   assign gnt_m1 = gnt_v[0];
   assign gnt_m2 = gnt_v[1];
endmodule

// File: tb/test_bus_hold_arb.sv
module test_bus_hold_arb;
   logic clk = 1'b0;
   logic rst, req_m1, req_m2, rdy_m1, rdy_m2;
   logic gnt_m1, gnt_m2;
   int   checks = 0;
   int   fails  = 0;
   int   owner  = 0;   // model: 0 free, 1 master 1, 2 master 2
   bit   done_run = 0;

   always #5 clk = ~clk;

   bus_hold_arb i_bus_hold_arb (
      .clk(clk), .rst(rst), .req_m1(req_m1), .req_m2(req_m2),
      .rdy_m1(rdy_m1), .rdy_m2(rdy_m2), .gnt_m1(gnt_m1), .gnt_m2(gnt_m2)
   );

   task automatic step(input logic r, input logic a, input logic b,
                       input logic ya, input logic yb, input string tag);
      logic e1, e2;
      @(negedge clk);
      rst = r; req_m1 = a; req_m2 = b; rdy_m1 = ya; rdy_m2 = yb;
      @(posedge clk);
      if (r) owner = 0;
      else if (owner == 0) begin
         if (a) owner = 1;
         else if (b) owner = 2;
      end else if (owner == 1 && ya) owner = 0;
      else if (owner == 2 && yb) owner = 0;
      #1;
      e1 = (owner == 1);
      e2 = (owner == 2);
      checks++;
      if (gnt_m1 !== e1 || gnt_m2 !== e2) begin
         fails++;
         $display("FAIL %s: gnt={%b,%b} expected {%b,%b}", tag,
                  gnt_m2, gnt_m1, e2, e1);
      end
   endtask

   initial begin
      #2000000;
      if (!done_run) begin
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr = 8'hA5;
      rst = 1; req_m1 = 0; req_m2 = 0; rdy_m1 = 0; rdy_m2 = 0;
      step(1, 0, 0, 0, 0, "R1");
      step(1, 1, 1, 1, 1, "R1");
      step(0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 1, "R2");
      // master 1 alone, held through foreign ready and request noise
      step(0, 1, 0, 0, 0, "R3");
      step(0, 0, 1, 0, 1, "R7");
      step(0, 0, 1, 0, 1, "R6");
      step(0, 1, 1, 0, 0, "R6");
      step(0, 0, 0, 1, 0, "R8");
      step(0, 0, 0, 0, 0, "R8");
      // tie
      step(0, 1, 1, 0, 0, "R4");
      step(0, 1, 1, 0, 1, "R7");
      step(0, 1, 1, 1, 0, "R8");
      step(0, 1, 1, 0, 0, "R8");   // regrant only after one free cycle
      step(0, 0, 0, 1, 0, "R8");
      // master 2 alone
      step(0, 0, 1, 0, 0, "R5");
      step(0, 0, 0, 1, 0, "R7");
      step(0, 1, 0, 0, 0, "R10");
      step(0, 0, 0, 0, 0, "R10");
      step(0, 0, 0, 0, 1, "R8");
      step(0, 0, 0, 0, 0, "R10");
      step(0, 0, 0, 0, 0, "R10");
      // mid-run reset
      step(0, 0, 1, 0, 0, "R5");
      step(1, 0, 1, 0, 0, "R1");
      step(0, 0, 0, 0, 0, "R2");
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(0, lfsr[0], lfsr[1], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6], "R9");
      end
      done_run = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule